// File: doc/BRIEF.md
# Indirect-Access I/O Interrupt Redirection Controller

This block collects interrupt events from numbered input pins and from PCI INTx lines and turns them into delivery messages for the processors. Each pin has a 64-bit redirection entry that holds a vector, a delivery mode, a trigger mode, a mask bit and a destination ID. Software never sees the table directly. It writes a select register, then reads or writes one 32-bit half of an entry through a data window. A write of a vector to the EOI register retires an interrupt.

The controller keeps a pending bit and an in-service bit per pin. When a pin is pending and not in service, it is a candidate, and the highest-numbered candidate goes out first. A level-triggered pin enters service when it is delivered and stays blocked until an EOI. An edge-triggered pin never enters service. The EOI is resolved by searching the table from index 0 upward for the first entry with the written vector. A PCI device/INTx pair is mapped to a pin by a fixed formula. Deliveries leave on a valid/ready channel, one per clock at most.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Only three byte offsets decode: 0x00 (select, read/write, 32 bits), 0x10 (data window) and 0x40 (EOI, write-only). A read of any other offset, and a read of 0x40, returns 0. A write to any other offset changes nothing.
- R2: While select holds 0x01, a window read returns (pin count − 1) in bits 23:16 and 0x21 in bits 7:0, with all other bits 0. That is 0x002F0021 for 48 pins. Window writes are then ignored.
- R3: For any other select value s, the entry index is (s − 0x10) >> 1. Odd s addresses bits 63:32 of the entry and even s addresses bits 31:0. A window write replaces only that half. Entry fields: vector [7:0], delivery mode [10:8], trigger [15] (1 = level), mask [16], destination [63:48].
- R4: If the computed index is not below the pin count, including select values below 0x10 that wrap, a window read returns 0 and a window write changes no entry.
- R5: After reset, select reads 0, no delivery is valid, nothing is pending or in service, and every entry reads 0x00010000 in its low half and 0 in its high half (only the mask set).
- R6: A pin event with a pin number ≥ pin count, or on a masked pin, is ignored. On a level-triggered pin the pending bit takes the event level. On an edge-triggered pin a high event sets pending and a low event does nothing.
- R7: Among the pins that are pending and not in service, the highest-numbered one is delivered first. Delivering a pin clears its pending bit. Delivering a level pin sets its in-service bit, which blocks further deliveries of that pin. An edge pin is never blocked.
- R8: An EOI write carries a vector in bits 7:0. The lowest-index entry with that vector is selected. If there is none, or its in-service bit is clear, nothing changes. Otherwise the in-service bit is cleared, and the pin is delivered again if it is pending.
- R9: A PCI event with device d (0–31) and line i (0–3) acts as a pin event on pin ((4·d + d/8 + i) mod 32) + 16. If a direct pin event arrives in the same cycle, the direct event is used and the PCI event is dropped.
- R10: A delivery carries destination, mode and vector of the entry at the time it starts. While valid is high and ready is low, valid and the payload hold, and no new delivery starts.
- R11: A pin event and an EOI in the same cycle both take effect before the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data is combinational) |
| bus_ofs | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |
| pin_evt | input | 1 | Direct pin event strobe |
| pin_num | input | 8 | Pin number of the event |
| pin_level | input | 1 | Line level of the event |
| pci_evt | input | 1 | PCI INTx event strobe |
| pci_dev | input | 5 | PCI device number |
| pci_intx | input | 2 | INTx line 0–3 |
| pci_level | input | 1 | Line level of the PCI event |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Receiver accepts the message |
| dlv_dest | output | 16 | Destination ID |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |

## Verification
If an in-service bit is stuck set, the pin goes silent until its vector is retired. That shows as a missing message a few cycles after the next event on that pin. If an in-service bit is lost, a level pin is delivered twice where the bench expects one delivery. A wrong priority pick shows as a reordered message sequence as soon as two candidates are pending together, for example while the channel stalls. Table and select corruption shows on the next window read, and on the vector, destination or mode of the next delivery from that pin.

// File: rtl/irq_redir_pkg.sv
// Package: shared constants and the delivery message type for the
// redirection controller. Assumes a 64-bit entry layout fixed below.
package irq_redir_pkg;
    localparam logic [7:0]  OFS_SELECT  = 8'h00;
    localparam logic [7:0]  OFS_WINDOW  = 8'h10;
    localparam logic [7:0]  OFS_EOI     = 8'h40;
    localparam logic [31:0] SEL_VERSION = 32'h0000_0001;
    localparam logic [31:0] ENTRY_BASE  = 32'h0000_0010;
    localparam logic [7:0]  VERSION_ID  = 8'h21;
    localparam int unsigned MAX_PINS    = 64;
    localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [15:0] dest;
        logic [2:0]  mode;
        logic [7:0]  vector;
    } dlv_msg_t;
endpackage

// File: rtl/irq_prio_pick.sv
// Module: picks one set bit of a request vector. FROM_LOW=1 returns the
// lowest set index, FROM_LOW=0 the highest. Purely combinational.
module irq_prio_pick #(
    parameter int unsigned WIDTH    = 48,
    parameter bit          FROM_LOW = 1'b0,
    localparam int unsigned IDX_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    assign any = |req;

    generate
        if (FROM_LOW) begin : g_low
            // Scan downward so the lowest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = WIDTH - 1; i >= 0; i--) begin
                    if (req[i]) idx = IDX_W'(i);
                end
            end
        end else begin : g_high
            // Scan upward so the highest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    if (req[i]) idx = IDX_W'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irq_pci_map.sv
// Module: fixed mapping of a PCI device and INTx line to an input pin,
// ((4*dev + dev/8 + intx) mod 32) + 16. Assumes the pin count exceeds 47.
module irq_pci_map (
    input  logic [4:0] dev,
    input  logic [1:0] intx,
    output logic [7:0] pin
);
    logic [6:0] sum;

    // Sum the three terms; only the low five bits survive the modulo.
    always_comb begin
        sum = {dev, 2'b00} + {5'b0, dev[4:3]} + {5'b0, intx};
        pin = {3'b000, sum[4:0]} + 8'd16;
    end
endmodule

// File: rtl/irq_regfile.sv
// Module: select register, redirection table and window decode.
// Read data is combinational; writes land on the clock edge. It also
// turns EOI writes into a one-cycle strobe with the vector.
module irq_regfile
    import irq_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_ofs,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] sel_cur,
    output logic        eoi_valid,
    output logic [7:0]  eoi_vector,
    output logic [7:0]  ent_vec   [NUM_PINS],
    output logic [2:0]  ent_mode  [NUM_PINS],
    output logic [15:0] ent_dest  [NUM_PINS],
    output logic [NUM_PINS-1:0] ent_level,
    output logic [NUM_PINS-1:0] ent_mask
);
    localparam logic [7:0]  PIN_TOP  = 8'(NUM_PINS - 1);
    localparam logic [30:0] PIN_LIM  = 31'(NUM_PINS);
    localparam logic [31:0] VER_WORD = {8'h00, PIN_TOP, 8'h00, VERSION_ID};

    logic [31:0] sel_q;
    logic [63:0] tbl [NUM_PINS];
    logic [31:0] rel;
    logic        in_range;
    logic        win_wr;
    logic [63:0] ent_rd;

    assign sel_cur  = sel_q;
    assign rel      = sel_q - ENTRY_BASE;
    assign in_range = (sel_q != SEL_VERSION) && (rel[31:1] < PIN_LIM);
    assign win_wr   = bus_wr && (bus_ofs == OFS_WINDOW) && in_range;

    assign eoi_valid  = bus_wr && (bus_ofs == OFS_EOI);
    assign eoi_vector = bus_wdata[7:0];

    // Select register: loaded by writes to the select offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                sel_q <= '0;
        else if (bus_wr && bus_ofs == OFS_SELECT)  sel_q <= bus_wdata;
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
            // Entry storage: reset to masked, half-word update through window.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[g] <= ENTRY_RESET;
                end else if (win_wr && rel[31:1] == 31'(g)) begin
                    if (rel[0]) tbl[g][63:32] <= bus_wdata;
                    else        tbl[g][31:0]  <= bus_wdata;
                end
            end
            assign ent_vec[g]   = tbl[g][7:0];
            assign ent_mode[g]  = tbl[g][10:8];
            assign ent_level[g] = tbl[g][15];
            assign ent_mask[g]  = tbl[g][16];
            assign ent_dest[g]  = tbl[g][63:48];
        end
    endgenerate

    // Window read mux over all entries.
    always_comb begin
        ent_rd = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rel[31:1] == 31'(i)) ent_rd = tbl[i];
        end
    end

    // Read data decode by offset and select value.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_ofs == OFS_SELECT) begin
                bus_rdata = sel_q;
            end else if (bus_ofs == OFS_WINDOW) begin
                if (sel_q == SEL_VERSION) bus_rdata = VER_WORD;
                else if (in_range)        bus_rdata = rel[0] ? ent_rd[63:32] : ent_rd[31:0];
            end
        end
    end
endmodule

// File: rtl/irq_service.sv
// Module: pending and in-service state, event and EOI handling, and the
// delivery register. One delivery may start per clock, chosen from the
// registered state; event and EOI effects land at the same edge.
module irq_service
    import irq_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 48,
    localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  ent_vec   [NUM_PINS],
    input  logic [2:0]  ent_mode  [NUM_PINS],
    input  logic [15:0] ent_dest  [NUM_PINS],
    input  logic [NUM_PINS-1:0] ent_level,
    input  logic [NUM_PINS-1:0] ent_mask,
    input  logic        ev_valid,
    input  logic [7:0]  ev_pin,
    input  logic        ev_level,
    input  logic        eoi_valid,
    input  logic [7:0]  eoi_vector,
    input  logic        dlv_ready,
    output logic        dlv_valid,
    output dlv_msg_t    dlv_msg,
    output logic [NUM_PINS-1:0] pend_o,
    output logic [NUM_PINS-1:0] insvc_o
);
    logic [NUM_PINS-1:0] pend_q, insvc_q, pend_n, insvc_n;
    logic [NUM_PINS-1:0] cand, vec_match;
    logic                cand_any, match_any, start;
    logic [IDX_W-1:0]    cand_idx, match_idx;

    assign pend_o  = pend_q;
    assign insvc_o = insvc_q;
    assign cand    = pend_q & ~insvc_q;
    assign start   = cand_any && (!dlv_valid || dlv_ready);

    // Highest-numbered candidate goes first.
    irq_prio_pick #(.WIDTH(NUM_PINS), .FROM_LOW(1'b0)) u_pick_hi (
        .req(cand), .any(cand_any), .idx(cand_idx)
    );

    // Vector comparison for the EOI search.
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) vec_match[i] = (ent_vec[i] == eoi_vector);
    end

    // EOI resolves to the lowest-index matching entry.
    irq_prio_pick #(.WIDTH(NUM_PINS), .FROM_LOW(1'b1)) u_pick_lo (
        .req(vec_match), .any(match_any), .idx(match_idx)
    );

    // Next-state of pending/in-service: service, then EOI, then event.
    always_comb begin
        pend_n  = pend_q;
        insvc_n = insvc_q;
        if (start) begin
            pend_n[cand_idx] = 1'b0;
            if (ent_level[cand_idx]) insvc_n[cand_idx] = 1'b1;
        end
        if (eoi_valid && match_any) insvc_n[match_idx] = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ev_valid && ev_pin == 8'(i) && !ent_mask[i]) begin
                if (ent_level[i])  pend_n[i] = ev_level;
                else if (ev_level) pend_n[i] = 1'b1;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
        end else begin
            pend_q  <= pend_n;
            insvc_q <= insvc_n;
        end
    end

    // Delivery register: load on start, drop after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid <= 1'b0;
            dlv_msg   <= '0;
        end else if (start) begin
            dlv_valid      <= 1'b1;
            dlv_msg.dest   <= ent_dest[cand_idx];
            dlv_msg.mode   <= ent_mode[cand_idx];
            dlv_msg.vector <= ent_vec[cand_idx];
        end else if (dlv_ready) begin
            dlv_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_redir_ctrl.sv
// Top: interrupt redirection controller. Joins register file, PCI pin
// mapping and servicing. A direct pin event wins over a PCI event that
// arrives in the same cycle.
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_ofs,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        pin_evt,
    input  logic [7:0]  pin_num,
    input  logic        pin_level,
    input  logic        pci_evt,
    input  logic [4:0]  pci_dev,
    input  logic [1:0]  pci_intx,
    input  logic        pci_level,
    output logic        dlv_valid,
    input  logic        dlv_ready,
    output logic [15:0] dlv_dest,
    output logic [2:0]  dlv_mode,
    output logic [7:0]  dlv_vector
);
    logic [7:0]  ent_vec  [NUM_PINS];
    logic [2:0]  ent_mode [NUM_PINS];
    logic [15:0] ent_dest [NUM_PINS];
    logic [NUM_PINS-1:0] ent_level, ent_mask, pend_vec, insvc_vec;
    logic [31:0] sel_cur;
    logic        eoi_valid;
    logic [7:0]  eoi_vector;
    logic [7:0]  pci_pin, ev_pin;
    logic        ev_valid, ev_level;
    dlv_msg_t    msg;

    irq_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_cur(sel_cur), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .ent_vec(ent_vec), .ent_mode(ent_mode), .ent_dest(ent_dest),
        .ent_level(ent_level), .ent_mask(ent_mask)
    );

    irq_pci_map u_pci (.dev(pci_dev), .intx(pci_intx), .pin(pci_pin));

    // Event source select: direct pin first, PCI otherwise.
    always_comb begin
        ev_valid = pin_evt || pci_evt;
        ev_pin   = pin_evt ? pin_num   : pci_pin;
        ev_level = pin_evt ? pin_level : pci_level;
    end

    irq_service #(.NUM_PINS(NUM_PINS)) u_svc (
        .clk(clk), .rst_n(rst_n), .ent_vec(ent_vec), .ent_mode(ent_mode),
        .ent_dest(ent_dest), .ent_level(ent_level), .ent_mask(ent_mask),
        .ev_valid(ev_valid), .ev_pin(ev_pin), .ev_level(ev_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_ready(dlv_ready),
        .dlv_valid(dlv_valid), .dlv_msg(msg), .pend_o(pend_vec), .insvc_o(insvc_vec)
    );

    assign dlv_dest   = msg.dest;
    assign dlv_mode   = msg.mode;
    assign dlv_vector = msg.vector;
endmodule

// File: rtl/irq_redir_chk.sv
// Checker: port-level and state-over-time properties of the controller,
// attached to every instance of the top by the bind below.
module irq_redir_chk
    import irq_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 48
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [7:0]  bus_ofs,
    input logic [31:0] bus_rdata,
    input logic [31:0] sel_cur,
    input logic        dlv_valid,
    input logic        dlv_ready,
    input logic [15:0] dlv_dest,
    input logic [2:0]  dlv_mode,
    input logic [7:0]  dlv_vector,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] insvc_vec
);
    localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_ID};
    logic [31:0] rel;
    assign rel = sel_cur - ENTRY_BASE;

    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ofs != OFS_SELECT && bus_ofs != OFS_WINDOW) |-> bus_rdata == 32'h0);

    assert_version_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ofs == OFS_WINDOW && sel_cur == SEL_VERSION) |-> bus_rdata == VER_EXP);

    assert_range_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ofs == OFS_WINDOW && sel_cur != SEL_VERSION &&
         rel[31:1] >= 31'(NUM_PINS)) |-> bus_rdata == 32'h0);

    assert_idle_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dlv_valid || dlv_ready) && (pend_vec & ~insvc_vec) == '0) |=> !dlv_valid);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable({dlv_dest, dlv_mode, dlv_vector})));
endmodule

bind irq_redir_ctrl irq_redir_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_ofs(bus_ofs),
    .bus_rdata(bus_rdata), .sel_cur(sel_cur), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_dest(dlv_dest), .dlv_mode(dlv_mode),
    .dlv_vector(dlv_vector), .pend_vec(pend_vec), .insvc_vec(insvc_vec)
);

// File: tb/irq_redir_ctrl_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic, checked
// against a behavioural model of the requirements.
module irq_redir_ctrl_tb_top;
    localparam int N = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_ofs = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        pin_evt = 0, pin_level = 0;
    logic [7:0]  pin_num = 0;
    logic        pci_evt = 0, pci_level = 0;
    logic [4:0]  pci_dev = 0;
    logic [1:0]  pci_intx = 0;
    logic        dlv_valid, dlv_ready = 1'b1;
    logic [15:0] dlv_dest;
    logic [2:0]  dlv_mode;
    logic [7:0]  dlv_vector;

    int  checks = 0, failures = 0;
    bit  done = 0;
    bit  rdy_low = 0, rdy_rand = 0;

    logic [63:0] m_tbl [64];
    logic [63:0] m_pend = 0, m_ins = 0;
    logic [31:0] m_sel = 0;
    logic [26:0] exp_q[$];
    logic [26:0] obs_q[$];

    irq_redir_ctrl #(.NUM_PINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_evt(pin_evt), .pin_num(pin_num), .pin_level(pin_level),
        .pci_evt(pci_evt), .pci_dev(pci_dev), .pci_intx(pci_intx),
        .pci_level(pci_level), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_dest(dlv_dest), .dlv_mode(dlv_mode), .dlv_vector(dlv_vector)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] dest, input bit mask,
                                       input bit lvl, input logic [2:0] mode,
                                       input logic [7:0] vec);
        return {dest, 31'b0, mask, lvl, 4'b0, mode, vec};
    endfunction

    function automatic int pci_pin(input int d, input int i);
        return ((4 * d + d / 8 + i) % 32) + 16;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] ofs);
        logic [31:0] o;
        o = m_sel - 32'h10;
        if (ofs == 8'h00) return m_sel;
        if (ofs == 8'h10) begin
            if (m_sel == 32'h1) return {8'h00, 8'(N - 1), 8'h00, 8'h21};
            if ((o >> 1) < N) return o[0] ? m_tbl[o >> 1][63:32] : m_tbl[o >> 1][31:0];
        end
        return 32'h0;
    endfunction

    task automatic m_service();
        while ((m_pend & ~m_ins) != 0) begin
            int h = 0;
            for (int i = 0; i < N; i++) if (m_pend[i] && !m_ins[i]) h = i;
            if (m_tbl[h][15]) m_ins[h] = 1'b1;
            exp_q.push_back({m_tbl[h][63:48], m_tbl[h][10:8], m_tbl[h][7:0]});
            m_pend[h] = 1'b0;
        end
    endtask

    task automatic m_event(input int pin, input bit lvl);
        if (pin >= N) return;
        if (m_tbl[pin][16]) return;
        if (m_tbl[pin][15]) m_pend[pin] = lvl;
        else if (lvl) m_pend[pin] = 1'b1;
    endtask

    task automatic m_eoi(input logic [7:0] v);
        for (int i = 0; i < N; i++) begin
            if (m_tbl[i][7:0] == v) begin
                m_ins[i] = 1'b0;
                return;
            end
        end
    endtask

    task automatic m_write(input logic [7:0] ofs, input logic [31:0] d);
        logic [31:0] o;
        o = m_sel - 32'h10;
        if (ofs == 8'h00) m_sel = d;
        else if (ofs == 8'h10) begin
            if (m_sel != 32'h1 && (o >> 1) < N) begin
                if (o[0]) m_tbl[o >> 1][63:32] = d;
                else      m_tbl[o >> 1][31:0]  = d;
            end
        end else if (ofs == 8'h40) m_eoi(d[7:0]);
    endtask

    task automatic settle();
        int idle = 0;
        for (int k = 0; k < 3000 && idle < 4; k++) begin
            @(negedge clk);
            if (dlv_valid) idle = 0; else idle++;
        end
    endtask

    task automatic compare(input string req);
        checks++;
        if (obs_q.size() != exp_q.size()) begin
            failures++;
            $display("FAIL %s delivery count actual=%0d expected=%0d", req, obs_q.size(), exp_q.size());
        end else begin
            foreach (exp_q[k]) check(req, 32'(obs_q[k]), 32'(exp_q[k]));
        end
        exp_q.delete();
        obs_q.delete();
    endtask

    task automatic bus_write(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_ofs = ofs; bus_wdata = d;
        m_write(ofs, d);
        @(negedge clk);
        bus_wr = 0;
        m_service();
    endtask

    task automatic bus_read(input logic [7:0] ofs, input string req);
        @(negedge clk);
        bus_rd = 1; bus_ofs = ofs;
        #2;
        check(req, bus_rdata, m_read(ofs));
        bus_rd = 0;
    endtask

    task automatic write_entry(input int idx, input logic [63:0] v);
        bus_write(8'h00, 32'h10 + 32'(2 * idx));
        bus_write(8'h10, v[31:0]);
        bus_write(8'h00, 32'h11 + 32'(2 * idx));
        bus_write(8'h10, v[63:32]);
    endtask

    task automatic pin_event(input int pin, input bit lvl, input bit svc);
        @(negedge clk);
        pin_evt = 1; pin_num = 8'(pin); pin_level = lvl;
        m_event(pin, lvl);
        @(negedge clk);
        pin_evt = 0;
        if (svc) m_service();
    endtask

    task automatic pci_event(input int d, input int i, input bit lvl);
        @(negedge clk);
        pci_evt = 1; pci_dev = 5'(d); pci_intx = 2'(i); pci_level = lvl;
        m_event(pci_pin(d, i), lvl);
        @(negedge clk);
        pci_evt = 0;
        m_service();
    endtask

    task automatic step(input string req);
        settle();
        compare(req);
    endtask

    // Ready driver, moved just after the rising edge.
    initial forever begin
        @(posedge clk);
        #2;
        dlv_ready = rdy_low ? 1'b0 : (rdy_rand ? 1'($urandom % 2) : 1'b1);
    end

    // Delivery monitor: record every accepted message.
    initial forever begin
        @(negedge clk);
        if (rst_n && dlv_valid && dlv_ready) obs_q.push_back({dlv_dest, dlv_mode, dlv_vector});
    end

    // Watchdog.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        for (int i = 0; i < 64; i++) m_tbl[i] = 64'h1_0000;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R5: reset state
        @(negedge clk);
        check("R5 valid after reset", 32'(dlv_valid), 32'h0);
        bus_read(8'h00, "R5 select reset");
        bus_write(8'h00, 32'h10);
        bus_read(8'h10, "R5 entry0 low");
        bus_write(8'h00, 32'h6F);
        bus_read(8'h10, "R5 entry47 high");

        // R2: version register
        bus_write(8'h00, 32'h1);
        bus_read(8'h10, "R2 version read");
        check("R2 version literal", m_read(8'h10), 32'h002F_0021);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, "R2 version after write");
        bus_write(8'h00, 32'h10);
        bus_read(8'h10, "R2 entry0 untouched");

        // R1: unmapped offsets
        bus_write(8'h20, 32'hDEAD_BEEF);
        bus_read(8'h20, "R1 unmapped read");
        bus_read(8'h40, "R1 eoi read");
        bus_read(8'h00, "R1 select after stray write");

        // R4: out of range index
        bus_write(8'h00, 32'h10 + 32'(2 * N));
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, "R4 index=N read");
        bus_write(8'h00, 32'h08);
        bus_write(8'h10, 32'h1111_2222);
        bus_read(8'h10, "R4 wrapped read");
        bus_write(8'h00, 32'h6E);
        bus_read(8'h10, "R4 entry47 low intact");

        // R3: half-word access
        write_entry(4, 64'h1122_3344_AABB_CCDD);
        bus_write(8'h00, 32'h18);
        bus_read(8'h10, "R3 entry4 low");
        bus_write(8'h10, 32'h0001_0055);
        bus_write(8'h00, 32'h19);
        bus_read(8'h10, "R3 entry4 high kept");

        // R6: masked edge pin, then unmasked
        write_entry(5, mk(16'h0A05, 1, 0, 3'd1, 8'h50));
        pin_event(5, 1, 1);
        step("R6 masked ignored");
        write_entry(5, mk(16'h0A05, 0, 0, 3'd1, 8'h50));
        step("R6 no pending from masked event");
        pin_event(5, 1, 1);
        step("R6 edge delivered");
        pin_event(5, 0, 1);
        step("R6 edge low no effect");
        pin_event(5, 1, 1);
        step("R7 edge not blocked");
        pin_event(60, 1, 1);
        step("R6 pin out of range");

        // R7 / R10: priority order under stall
        write_entry(2, mk(16'h0002, 0, 0, 3'd0, 8'h22));
        write_entry(20, mk(16'h0014, 0, 0, 3'd2, 8'h34));
        write_entry(40, mk(16'h0028, 0, 0, 3'd4, 8'hA8));
        rdy_low = 1;
        repeat (2) @(negedge clk);
        pin_event(2, 1, 1);
        pin_event(5, 1, 0);
        pin_event(40, 1, 0);
        pin_event(20, 1, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 stall valid", 32'(dlv_valid), 32'h1);
            check("R10 stall payload", {5'b0, dlv_dest, dlv_mode, dlv_vector}, 32'({16'h0002, 3'd0, 8'h22}));
        end
        m_service();
        rdy_low = 0;
        step("R7 highest first order");

        // R7 / R8: level pin held in service
        write_entry(30, mk(16'h001E, 0, 1, 3'd5, 8'h9E));
        pin_event(30, 1, 1);
        step("R7 level delivered");
        pin_event(30, 1, 1);
        step("R7 level blocked in service");
        bus_write(8'h40, 32'h9E);
        step("R8 eoi redelivers pending");
        bus_write(8'h40, 32'h9E);
        step("R8 eoi no pending");
        bus_write(8'h40, 32'h9E);
        step("R8 eoi not in service");
        pin_event(30, 0, 1);
        bus_write(8'h40, 32'hEE);
        step("R8 eoi no match");

        // R8: duplicate vectors resolve to lowest index
        write_entry(3, mk(16'h0003, 0, 1, 3'd0, 8'h77));
        write_entry(10, mk(16'h000A, 0, 1, 3'd0, 8'h77));
        pin_event(10, 1, 1);
        step("R8 dup pin delivered");
        bus_write(8'h40, 32'h77);
        pin_event(10, 1, 1);
        step("R8 eoi hit lower index");
        write_entry(3, mk(16'h0003, 0, 1, 3'd0, 8'h78));
        bus_write(8'h40, 32'h77);
        step("R8 eoi reaches pin10");

        // R9: PCI mapping and precedence
        check("R9 map 7/2", 32'(pci_pin(7, 2)), 32'd46);
        write_entry(46, mk(16'h002E, 0, 0, 3'd1, 8'hC6));
        pci_event(7, 2, 1);
        step("R9 pci to pin46");
        write_entry(18, mk(16'h0012, 0, 0, 3'd1, 8'hB2));
        @(negedge clk);
        pin_evt = 1; pin_num = 8'd2; pin_level = 1;
        pci_evt = 1; pci_dev = 5'd31; pci_intx = 2'd3; pci_level = 1;
        m_event(2, 1);
        @(negedge clk);
        pin_evt = 0; pci_evt = 0;
        m_service();
        step("R9 direct wins over pci");

        // R11: event and EOI in the same cycle
        pin_event(30, 1, 1);
        step("R11 setup delivery");
        @(negedge clk);
        bus_wr = 1; bus_ofs = 8'h40; bus_wdata = 32'h9E;
        pin_evt = 1; pin_num = 8'd30; pin_level = 1;
        m_eoi(8'h9E);
        m_event(30, 1);
        @(negedge clk);
        bus_wr = 0; pin_evt = 0;
        m_service();
        step("R11 both applied");

        // Random phase
        rdy_rand = 1;
        for (int i = 0; i < N; i++)
            write_entry(i, mk(16'($urandom), ($urandom % 4) == 0, 1'($urandom), 3'($urandom), 8'($urandom)));
        for (int it = 0; it < 500; it++) begin
            int op = $urandom % 6;
            case (op)
                0: pin_event($urandom % 64, 1'($urandom), 1);
                1: pci_event($urandom % 32, $urandom % 4, 1'($urandom));
                2: bus_write(8'h40, ($urandom % 3 == 0) ? 32'($urandom % 256)
                                                        : 32'(m_tbl[$urandom % N][7:0]));
                3: begin
                    bus_write(8'h00, 32'h10 + 32'($urandom % (2 * N + 6)));
                    bus_read(8'h10, "R3 random window read");
                end
                4: begin
                    bus_write(8'h00, ($urandom % 8 == 0) ? $urandom : 32'h10 + 32'($urandom % (2 * N + 4)));
                    bus_write(8'h10, $urandom);
                end
                default: bus_read(8'($urandom % 4) << 4, "R1 random offset read");
            endcase
            step("R7 random delivery stream");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule